// File: doc/BRIEF.md
# I2C High-Level Command Engine

This block runs a complete short I2C master transaction from a single 64-bit command word. Software loads an optional extension word, then writes the command with its valid bit set. The engine then drives a byte-level bus engine through start, address, optional internal-address, data and stop steps with no further software action. It raises a one-cycle interrupt when it finishes. Up to eight data bytes travel inside the two words, packed in reverse so that the last byte of the message sits in the lowest byte lane.

The supported transactions are a plain read, a plain write, an internal-address write followed by a read after a repeated start, and an internal-address write followed by data. Each can use 7-bit or 10-bit target addressing. When the transaction ends, the command word is the report. On a successful read, the received bytes replace the data lanes. On any failure, the read flag is cleared and the low byte holds a status code. Bit timing on the wires, arbitration recovery and target mode belong to other blocks.

Top module: `i2c_hlc_engine`

## Requirements
- R1: Writing the command with bit 63 set starts a transaction, and the first bus request is then a start. Bit 63 stays set while the engine is busy. It clears in the same cycle that `irq` rises, and `irq` is high for exactly one cycle.
- R2: While bit 63 is set, writes to the command and extension words are ignored. Both words, except the data lanes and the result fields, read back unchanged.
- R3: Bus requests use `be_op` codes 0 = start, 1 = stop, 2 = transmit `be_txd`, 3 = receive. Only one request is outstanding until `be_done`. A successful transaction always ends with a stop.
- R4: Bits 54:52 hold the byte count minus one, so a transaction moves 1 to 8 data bytes.
- R5: The data lanes run 0..7. Lanes 0-3 are command bits 31:0 and lanes 4-7 are extension bits 31:0, each lane 8 bits with lane 0 at bits 7:0. Message byte k (k = 0 first on the wire) uses lane (count-1-k).
- R6: Opcode bits 61:57 take these values: 0 is 7-bit plain, 1 is 7-bit with internal address, 2 is 10-bit plain, 3 is 10-bit with internal address. The target address is in bits 49:40. A 7-bit address byte is {addr[6:0], rw}. A 10-bit address is sent as {11110, addr[9:8], 0} then addr[7:0].
- R7: Bit 56 requests a read. Every received byte is acknowledged except the last (`be_ack` = 1 means acknowledge). On success, bit 56 reads back as 1 and only the lanes that were read are overwritten.
- R8: With an internal address, the engine first sends the address with the write bit, then sends command bits 39:32. If bit 50 is set, the engine sends extension bits 39:32 before command bits 39:32.
- R9: A read that follows an internal address, or any 10-bit read, issues a repeated start after the write phase. It then sends the read address byte: {addr[6:0],1} for 7-bit targets, {11110,addr[9:8],1} for 10-bit targets.
- R10: A NAK on an address byte makes the engine issue a stop next. It then reports status 0x20 for write-direction addressing or 0x48 for read-direction addressing, with bit 56 cleared.
- R11: A NAK on an internal-address byte or a transmitted data byte ends the transaction with a stop and status 0x30.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Write strobe for the command word |
| cmd_wdata | input | 64 | Command word write data |
| ext_wr | input | 1 | Write strobe for the extension word |
| ext_wdata | input | 64 | Extension word write data |
| cmd_rdata | output | 64 | Current command word and result |
| ext_rdata | output | 64 | Current extension word |
| irq | output | 1 | One-cycle completion pulse |
| be_req | output | 1 | Bus engine request strobe |
| be_op | output | 2 | Bus engine operation code |
| be_txd | output | 8 | Byte to transmit |
| be_ack | output | 1 | Acknowledge to send after a received byte |
| be_done | input | 1 | Bus engine finished the request |
| be_nak | input | 1 | Transmitted byte was not acknowledged |
| be_rxd | input | 8 | Received byte, valid with be_done |

## Verification
Writes of three and eight bytes tell apart lane order within the command word from the crossing into the extension word. Reads of one, four, six and eight bytes do three things: they show the final-byte NAK on a single-byte read, they show that untouched lanes are kept, and they show the reverse placement of received data. Ten-bit and internal-address cases, including the two-byte internal address and a ten-bit plain read, separate the single-phase address paths from the repeated-start paths. NAKs placed on the first address, on a data byte and on the repeated read address tell the three status codes apart. A second command written mid-transaction shows that the busy guard holds.

// File: rtl/i2c_hlc_pkg.sv
package i2c_hlc_pkg;
  localparam int BYTE_W     = 8;
  localparam int NUM_LANES  = 8;
  localparam int WORD_LANES = NUM_LANES / 2;
  localparam int LANE_IW    = $clog2(NUM_LANES);
  localparam int ADDR_W     = 10;
  localparam int WORD_W     = 64;

  localparam int VALID_BIT  = 63;
  localparam int OPC_LSB    = 57;
  localparam int RD_BIT     = 56;
  localparam int SIZE_LSB   = 52;
  localparam int EIA_BIT    = 50;
  localparam int ADDR_LSB   = 40;
  localparam int IA_LSB     = 32;

  localparam logic [BYTE_W-1:0] ST_WADDR_NAK = 8'h20;
  localparam logic [BYTE_W-1:0] ST_DATA_NAK  = 8'h30;
  localparam logic [BYTE_W-1:0] ST_RADDR_NAK = 8'h48;
  localparam logic [4:0]        TEN_PREFIX   = 5'b11110;

  typedef enum logic [1:0] {
    BE_START = 2'd0,
    BE_STOP  = 2'd1,
    BE_TX    = 2'd2,
    BE_RX    = 2'd3
  } be_op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_A7, S_A10H, S_A10L, S_IAH, S_IAL,
    S_RSTART, S_RA, S_WR, S_RD, S_STOP
  } seq_state_e;
endpackage

// File: rtl/i2c_hlc_rst_sync.sv
module i2c_hlc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/i2c_hlc_lane_sel.sv
module i2c_hlc_lane_sel
  import i2c_hlc_pkg::*;
#(
  parameter int LANES = NUM_LANES,
  parameter int BW    = BYTE_W,
  localparam int IW   = $clog2(LANES),
  localparam int HALF = LANES / 2
) (
  input  logic [HALF*BW-1:0] cmd_lo,
  input  logic [HALF*BW-1:0] ext_lo,
  input  logic [IW-1:0]      last_idx,
  input  logic [IW-1:0]      cur_idx,
  output logic [IW-1:0]      pos,
  output logic [BW-1:0]      tx_byte
);
  logic [BW-1:0] lane [LANES];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    if (l < HALF) begin : g_cmd
      assign lane[l] = cmd_lo[l*BW +: BW];
    end else begin : g_ext
      assign lane[l] = ext_lo[(l-HALF)*BW +: BW];
    end
  end

  // message byte k lives in lane (last - k)
  assign pos     = last_idx - cur_idx;
  assign tx_byte = lane[pos];
endmodule

// File: rtl/i2c_hlc_seq.sv
module i2c_hlc_seq
  import i2c_hlc_pkg::*;
#(
  parameter int IW = LANE_IW,
  parameter int AW = ADDR_W,
  parameter int BW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          rd_i,
  input  logic          ia_i,
  input  logic          ten_i,
  input  logic          eia_i,
  input  logic [AW-1:0] addr_i,
  input  logic [BW-1:0] ia_lo_i,
  input  logic [BW-1:0] ia_hi_i,
  input  logic [IW-1:0] last_i,
  input  logic [BW-1:0] tx_data_i,
  input  logic          be_done_i,
  input  logic          be_nak_i,
  output logic          be_req_o,
  output be_op_e        be_op_o,
  output logic [BW-1:0] be_txd_o,
  output logic          be_ack_o,
  output logic [IW-1:0] idx_o,
  output logic          rx_we_o,
  output logic          fin_o,
  output logic          fail_o,
  output logic [BW-1:0] code_o
);
  seq_state_e    state_q, state_d;
  logic          wait_q, wait_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          fail_q, fail_d;
  logic [BW-1:0] code_q, code_d;
  logic          step, nak_hit, first_rd, at_last;
  seq_state_e    after_addr;

  assign step     = wait_q && be_done_i;
  assign nak_hit  = step && be_nak_i;
  assign first_rd = rd_i && !ia_i && !ten_i;
  assign at_last  = (idx_q == last_i);

  always_comb begin
    if (ia_i)      after_addr = eia_i ? S_IAH : S_IAL;
    else if (rd_i) after_addr = ten_i ? S_RSTART : S_RD;
    else           after_addr = S_WR;
  end

  // request content per state
  always_comb begin
    be_op_o  = BE_TX;
    be_txd_o = '0;
    be_ack_o = 1'b0;
    unique case (state_q)
      S_START, S_RSTART: be_op_o = BE_START;
      S_STOP:            be_op_o = BE_STOP;
      S_A7:              be_txd_o = {addr_i[6:0], first_rd};
      S_A10H:            be_txd_o = {TEN_PREFIX, addr_i[9:8], 1'b0};
      S_A10L:            be_txd_o = addr_i[7:0];
      S_IAH:             be_txd_o = ia_hi_i;
      S_IAL:             be_txd_o = ia_lo_i;
      S_RA:              be_txd_o = ten_i ? {TEN_PREFIX, addr_i[9:8], 1'b1}
                                          : {addr_i[6:0], 1'b1};
      S_WR:              be_txd_o = tx_data_i;
      S_RD: begin
        be_op_o  = BE_RX;
        be_ack_o = !at_last;
      end
      default: be_op_o = BE_TX;
    endcase
  end

  // next state
  always_comb begin
    state_d  = state_q;
    wait_d   = wait_q;
    idx_d    = idx_q;
    fail_d   = fail_q;
    code_d   = code_q;
    be_req_o = 1'b0;
    rx_we_o  = 1'b0;
    fin_o    = 1'b0;
    if (state_q == S_IDLE) begin
      if (start_i) begin
        state_d = S_START;
        wait_d  = 1'b0;
        idx_d   = '0;
        fail_d  = 1'b0;
        code_d  = '0;
      end
    end else if (!wait_q) begin
      be_req_o = 1'b1;
      wait_d   = 1'b1;
    end else if (step) begin
      wait_d = 1'b0;
      unique case (state_q)
        S_START:  state_d = ten_i ? S_A10H : S_A7;
        S_A7: begin
          if (nak_hit) begin
            fail_d  = 1'b1;
            code_d  = first_rd ? ST_RADDR_NAK : ST_WADDR_NAK;
            state_d = S_STOP;
          end else state_d = after_addr;
        end
        S_A10H: begin
          if (nak_hit) begin
            fail_d  = 1'b1;
            code_d  = ST_WADDR_NAK;
            state_d = S_STOP;
          end else state_d = S_A10L;
        end
        S_A10L: begin
          if (nak_hit) begin
            fail_d  = 1'b1;
            code_d  = ST_WADDR_NAK;
            state_d = S_STOP;
          end else state_d = after_addr;
        end
        S_IAH: begin
          if (nak_hit) begin
            fail_d  = 1'b1;
            code_d  = ST_DATA_NAK;
            state_d = S_STOP;
          end else state_d = S_IAL;
        end
        S_IAL: begin
          if (nak_hit) begin
            fail_d  = 1'b1;
            code_d  = ST_DATA_NAK;
            state_d = S_STOP;
          end else state_d = rd_i ? S_RSTART : S_WR;
        end
        S_RSTART: state_d = S_RA;
        S_RA: begin
          if (nak_hit) begin
            fail_d  = 1'b1;
            code_d  = ST_RADDR_NAK;
            state_d = S_STOP;
          end else state_d = S_RD;
        end
        S_WR: begin
          if (nak_hit) begin
            fail_d  = 1'b1;
            code_d  = ST_DATA_NAK;
            state_d = S_STOP;
          end else if (at_last) state_d = S_STOP;
          else idx_d = idx_q + 1'b1;
        end
        S_RD: begin
          rx_we_o = 1'b1;
          if (at_last) state_d = S_STOP;
          else idx_d = idx_q + 1'b1;
        end
        S_STOP: begin
          fin_o   = 1'b1;
          state_d = S_IDLE;
        end
        default: state_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      wait_q  <= 1'b0;
      idx_q   <= '0;
      fail_q  <= 1'b0;
      code_q  <= '0;
    end else begin
      state_q <= state_d;
      wait_q  <= wait_d;
      idx_q   <= idx_d;
      fail_q  <= fail_d;
      code_q  <= code_d;
    end
  end

  assign idx_o  = idx_q;
  assign fail_o = fail_q;
  assign code_o = code_q;
endmodule

// File: rtl/i2c_hlc_engine.sv
module i2c_hlc_engine
  import i2c_hlc_pkg::*;
#(
  parameter int W  = WORD_W,
  parameter int BW = BYTE_W,
  localparam int IW   = LANE_IW,
  localparam int HALF = WORD_LANES * BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_wr,
  input  logic [W-1:0]  cmd_wdata,
  input  logic          ext_wr,
  input  logic [W-1:0]  ext_wdata,
  output logic [W-1:0]  cmd_rdata,
  output logic [W-1:0]  ext_rdata,
  output logic          irq,
  output logic          be_req,
  output logic [1:0]    be_op,
  output logic [BW-1:0] be_txd,
  output logic          be_ack,
  input  logic          be_done,
  input  logic          be_nak,
  input  logic [BW-1:0] be_rxd
);
  logic            rst_n_s;
  logic [W-1:0]    cmd_q, cmd_d, ext_q, ext_d;
  logic [2*HALF-1:0] lanes_d;
  logic            irq_q;
  logic            start, busy;
  logic [IW-1:0]   idx, pos;
  logic [BW-1:0]   tx_byte, code;
  logic            rx_we, fin, fail;
  be_op_e          op;

  i2c_hlc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  assign busy = cmd_q[VALID_BIT];

  i2c_hlc_lane_sel u_sel (
    .cmd_lo   (cmd_q[HALF-1:0]),
    .ext_lo   (ext_q[HALF-1:0]),
    .last_idx (cmd_q[SIZE_LSB +: IW]),
    .cur_idx  (idx),
    .pos      (pos),
    .tx_byte  (tx_byte)
  );

  i2c_hlc_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .start_i   (start),
    .rd_i      (cmd_q[RD_BIT]),
    .ia_i      (cmd_q[OPC_LSB]),
    .ten_i     (cmd_q[OPC_LSB+1]),
    .eia_i     (cmd_q[EIA_BIT]),
    .addr_i    (cmd_q[ADDR_LSB +: ADDR_W]),
    .ia_lo_i   (cmd_q[IA_LSB +: BW]),
    .ia_hi_i   (ext_q[IA_LSB +: BW]),
    .last_i    (cmd_q[SIZE_LSB +: IW]),
    .tx_data_i (tx_byte),
    .be_done_i (be_done),
    .be_nak_i  (be_nak),
    .be_req_o  (be_req),
    .be_op_o   (op),
    .be_txd_o  (be_txd),
    .be_ack_o  (be_ack),
    .idx_o     (idx),
    .rx_we_o   (rx_we),
    .fin_o     (fin),
    .fail_o    (fail),
    .code_o    (code)
  );

  always_comb begin
    cmd_d = cmd_q;
    ext_d = ext_q;
    start = 1'b0;
    if (!busy) begin
      if (ext_wr) ext_d = ext_wdata;
      if (cmd_wr) begin
        cmd_d = cmd_wdata;
        start = cmd_wdata[VALID_BIT];
      end
    end
    lanes_d = {ext_d[HALF-1:0], cmd_d[HALF-1:0]};
    if (rx_we) lanes_d[pos*BW +: BW] = be_rxd;
    cmd_d[HALF-1:0] = lanes_d[HALF-1:0];
    ext_d[HALF-1:0] = lanes_d[2*HALF-1:HALF];
    if (fin) begin
      cmd_d[VALID_BIT] = 1'b0;
      if (fail) begin
        cmd_d[RD_BIT]  = 1'b0;
        cmd_d[BW-1:0]  = code;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      cmd_q <= '0;
      ext_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (cmd_wr || rx_we || fin) cmd_q <= cmd_d;
      if (ext_wr || rx_we)        ext_q <= ext_d;
      irq_q <= fin;
    end
  end

  assign cmd_rdata = cmd_q;
  assign ext_rdata = ext_q;
  assign irq       = irq_q;
  assign be_op     = op;
endmodule

// File: rtl/i2c_hlc_checker.sv
module i2c_hlc_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        ext_wr,
  input logic [63:0] cmd_rdata,
  input logic [63:0] ext_rdata,
  input logic        irq,
  input logic        be_req,
  input logic [1:0]  be_op,
  input logic        be_done,
  input logic        be_nak
);
  p_start_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_rdata[63]) |-> (be_req && be_op == 2'd0));

  p_clear_with_irq_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmd_rdata[63]) |-> irq);

  p_irq_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  p_req_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    be_req |-> cmd_rdata[63]);

  p_one_outstanding_r3: assert property (@(posedge clk) disable iff (!rst_n)
    be_req |=> !be_req);

  p_fields_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rdata[63] |=> $stable(cmd_rdata[55:32]));

  p_ext_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_rdata[63] && ext_wr) |=> $stable(ext_rdata[63:32]));

  p_nak_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (be_done && be_nak) |=> (be_req && be_op == 2'd1));
endmodule

bind i2c_hlc_engine i2c_hlc_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ext_wr    (ext_wr),
  .cmd_rdata (cmd_rdata),
  .ext_rdata (ext_rdata),
  .irq       (irq),
  .be_req    (be_req),
  .be_op     (be_op),
  .be_done   (be_done),
  .be_nak    (be_nak)
);

// File: tb/test_i2c_hlc_engine.sv
module test_i2c_hlc_engine;
  localparam int CLK_NS = 10;

  logic        clk, rst_n;
  logic        cmd_wr, ext_wr;
  logic [63:0] cmd_wdata, ext_wdata, cmd_rdata, ext_rdata;
  logic        irq, be_req, be_ack, be_done, be_nak;
  logic [1:0]  be_op;
  logic [7:0]  be_txd, be_rxd;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [10:0] exp_q[$];
  bit          exp_cut;
  int          exp_txn, exp_nak;
  logic [7:0]  exp_stat;
  string       cur_req;

  int         eng_tx, eng_rx, eng_nak_at;
  logic [7:0] rx_seed;

  i2c_hlc_engine i_i2c_hlc_engine (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
    .ext_wr(ext_wr), .ext_wdata(ext_wdata), .cmd_rdata(cmd_rdata),
    .ext_rdata(ext_rdata), .irq(irq), .be_req(be_req), .be_op(be_op),
    .be_txd(be_txd), .be_ack(be_ack), .be_done(be_done), .be_nak(be_nak),
    .be_rxd(be_rxd)
  );

  initial clk = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input logic [4:0] opc, input logic rd,
      input logic [2:0] sz, input logic eia, input logic [9:0] a, input logic [7:0] ia);
    logic [63:0] c;
    c = 64'd0;
    c[63] = 1'b1; c[61:57] = opc; c[56] = rd; c[54:52] = sz;
    c[50] = eia; c[49:40] = a; c[39:32] = ia;
    return c;
  endfunction

  task automatic push_ev(input logic [1:0] op, input logic ack, input logic [7:0] b);
    if (!exp_cut) exp_q.push_back({op, ack, b});
  endtask

  task automatic push_tx(input logic [7:0] b, input logic [7:0] st);
    if (exp_cut) return;
    push_ev(2'd2, 1'b0, b);
    if (exp_txn == exp_nak) begin
      exp_stat = st;
      push_ev(2'd1, 1'b0, 8'h00);
      exp_cut = 1;
    end
    exp_txn++;
  endtask

  // bus engine model and monitor: compares each request with the scoreboard
  initial begin
    logic [1:0]  op;
    logic [7:0]  b;
    logic        ak;
    logic [10:0] it;
    be_done = 0; be_nak = 0; be_rxd = 0;
    @(negedge clk);
    forever begin
      if (be_req === 1'b1) begin
        op = be_op; b = be_txd; ak = be_ack;
        if (exp_q.size() == 0) begin
          chk(0, cur_req, "unexpected bus request (R3)", {62'd0, op}, 64'hFF);
        end else begin
          it = exp_q.pop_front();
          chk(op == it[10:9], cur_req, "bus op (R3)", {62'd0, op}, {62'd0, it[10:9]});
          if (it[10:9] == 2'd2)
            chk(b == it[7:0], cur_req, "tx byte", {56'd0, b}, {56'd0, it[7:0]});
          if (it[10:9] == 2'd3)
            chk(ak == it[8], cur_req, "rx ack (R7)", {63'd0, ak}, {63'd0, it[8]});
        end
        repeat (2) @(negedge clk);
        be_done = 1; be_nak = 0;
        if (op == 2'd2) begin
          be_nak = (eng_tx == eng_nak_at);
          eng_tx++;
        end
        if (op == 2'd3) begin
          be_rxd = rx_seed + 8'(eng_rx);
          eng_rx++;
        end
        @(negedge clk);
        be_done = 0; be_nak = 0;
      end else @(negedge clk);
    end
  end

  task automatic run_txn(input string req, input logic [63:0] c, input logic [63:0] e,
                         input int nak_at, input logic [7:0] seed, input bit poke);
    logic rd, ia, ten, eia;
    logic [9:0] a;
    int n, pos;
    bit got;
    logic [63:0] ec, ee;
    cur_req = req;
    rd = c[56]; ia = c[57]; ten = c[58]; eia = c[50]; a = c[49:40];
    n = int'(c[54:52]) + 1;
    exp_q.delete(); exp_cut = 0; exp_txn = 0; exp_nak = nak_at; exp_stat = 0;
    eng_tx = 0; eng_rx = 0; eng_nak_at = nak_at; rx_seed = seed;
    push_ev(2'd0, 1'b0, 8'h00);
    if (ten) begin
      push_tx({5'b11110, a[9:8], 1'b0}, 8'h20);
      push_tx(a[7:0], 8'h20);
    end else begin
      push_tx({a[6:0], rd & ~ia}, (rd & ~ia) ? 8'h48 : 8'h20);
    end
    if (ia) begin
      if (eia) push_tx(e[39:32], 8'h30);
      push_tx(c[39:32], 8'h30);
    end
    if (rd && (ia || ten)) begin
      push_ev(2'd0, 1'b0, 8'h00);
      push_tx(ten ? {5'b11110, a[9:8], 1'b1} : {a[6:0], 1'b1}, 8'h48);
    end
    for (int k = 0; k < n; k++) begin
      pos = n - 1 - k;
      if (rd) push_ev(2'd3, k != n - 1, 8'h00);
      else push_tx(pos < 4 ? c[pos*8 +: 8] : e[(pos-4)*8 +: 8], 8'h30);
    end
    push_ev(2'd1, 1'b0, 8'h00);
    // expected final words
    ec = c; ee = e; ec[63] = 1'b0;
    if (exp_cut) begin
      ec[56] = 1'b0; ec[7:0] = exp_stat;
    end else if (rd) begin
      for (int k = 0; k < n; k++) begin
        pos = n - 1 - k;
        if (pos < 4) ec[pos*8 +: 8] = seed + 8'(k);
        else ee[(pos-4)*8 +: 8] = seed + 8'(k);
      end
    end
    @(negedge clk); ext_wr = 1; ext_wdata = e;
    @(negedge clk); ext_wr = 0; cmd_wr = 1; cmd_wdata = c;
    @(negedge clk); cmd_wr = 0;
    chk(cmd_rdata[63] == 1'b1, "R1", "valid after start", cmd_rdata, c);
    if (poke) begin
      repeat (3) @(negedge clk);
      cmd_wr = 1; cmd_wdata = ~c | 64'h8000_0000_0000_0000;
      ext_wr = 1; ext_wdata = ~e;
      @(negedge clk); cmd_wr = 0; ext_wr = 0;
      chk(cmd_rdata == c, "R2", "cmd after busy write", cmd_rdata, c);
      chk(ext_rdata == e, "R2", "ext after busy write", ext_rdata, e);
    end
    got = 0;
    for (int i = 0; i < 4000; i++) begin
      if (irq === 1'b1) begin got = 1; break; end
      @(negedge clk);
    end
    chk(got, "R1", {req, " irq seen"}, {63'd0, got}, 64'd1);
    chk(exp_q.size() == 0, "R3", {req, " all bus steps issued"}, exp_q.size(), 64'd0);
    chk(cmd_rdata == ec, req, "command result", cmd_rdata, ec);
    chk(ext_rdata == ee, req, "extension result", ext_rdata, ee);
    @(negedge clk);
    chk(irq == 1'b0, "R1", "irq one cycle", {63'd0, irq}, 64'd0);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    cur_req = "reset";
    exp_cut = 0; exp_txn = 0; exp_nak = -1; exp_stat = 0;
    eng_tx = 0; eng_rx = 0; eng_nak_at = -1; rx_seed = 0;
    rst_n = 0; cmd_wr = 0; ext_wr = 0; cmd_wdata = 0; ext_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(cmd_rdata == 64'd0 && ext_rdata == 64'd0, "R1", "reset words", cmd_rdata, 64'd0);
    chk(irq == 0 && be_req == 0, "R1", "reset outputs", {62'd0, irq, be_req}, 64'd0);

    // R4 R5: 3-byte and 8-byte writes, 7-bit target
    run_txn("R5", mk(5'd0, 0, 3'd2, 0, 10'h052, 8'h00) | 64'h00A1B2C3, 64'd0, -1, 8'h00, 0);
    run_txn("R4", mk(5'd0, 0, 3'd7, 0, 10'h033, 8'h00) | 64'h11223344,
            64'h0000_0000_5566_7788, -1, 8'h00, 0);
    // R7: reads of 1 and 6 bytes
    run_txn("R7", mk(5'd0, 1, 3'd0, 0, 10'h02C, 8'h00) | 64'hDEADBEEF, 64'd0, -1, 8'h90, 0);
    run_txn("R7", mk(5'd0, 1, 3'd5, 0, 10'h07F, 8'h00) | 64'h01020304,
            64'h0000_0000_CAFE_F00D, -1, 8'h40, 0);
    // R6 R9: 10-bit write and 10-bit read with repeated start
    run_txn("R6", mk(5'd2, 0, 3'd1, 0, 10'h2A5, 8'h00) | 64'h0000BEEF, 64'd0, -1, 8'h00, 0);
    run_txn("R9", mk(5'd2, 1, 3'd3, 0, 10'h1C3, 8'h00), 64'd0, -1, 8'h10, 0);
    // R8: one-byte internal address write; two-byte internal address read
    run_txn("R8", mk(5'd1, 0, 3'd1, 0, 10'h050, 8'h7E) | 64'h00005A5A, 64'd0, -1, 8'h00, 0);
    run_txn("R8", mk(5'd1, 1, 3'd7, 1, 10'h051, 8'h34), 64'h0000_0012_0000_0000, -1, 8'hC0, 0);
    run_txn("R9", mk(5'd3, 1, 3'd0, 0, 10'h3FF, 8'h99), 64'd0, -1, 8'h01, 0);
    // R10 R11: NAK cases
    run_txn("R10", mk(5'd0, 1, 3'd1, 0, 10'h011, 8'h00) | 64'h12345678, 64'd0, 0, 8'h00, 0);
    run_txn("R10", mk(5'd0, 0, 3'd1, 0, 10'h012, 8'h00) | 64'h12345678, 64'd0, 0, 8'h00, 0);
    run_txn("R11", mk(5'd0, 0, 3'd3, 0, 10'h013, 8'h00) | 64'hAABBCCDD, 64'd0, 2, 8'h00, 0);
    run_txn("R10", mk(5'd1, 1, 3'd2, 0, 10'h014, 8'h21), 64'd0, 2, 8'h00, 0);
    // R2: writes while busy are ignored
    run_txn("R2", mk(5'd0, 0, 3'd4, 0, 10'h015, 8'h00) | 64'h99887766,
            64'h0000_0000_0000_0055, -1, 8'h00, 1);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule